// File: doc/BRIEF.md
# Floating-Point Operate Instruction Decoder

This block takes a 32-bit floating-point operate instruction word and, with no clock and no state, works out what the word asks for. It decides whether the word belongs to the arithmetic/conversion group or the compare group, looks up the 9-bit operation field in that group's table, and reports the precision of each of the three register operands. A compare has no register destination. Its result goes to the floating-point condition codes, and the block reports that destination on its own flag.

Once the sizes are known, the block checks each register number against the precision its opcode implies. A double operand needs an even register, and a quad operand needs a register that is a multiple of four. A compare must name register zero as its destination. Any breach raises an invalid-register error with trap type 6 and marks the instruction as not executable.

A pipeline front end or a trap handler uses the outputs to pick an execution unit and to steer register-file reads. The block performs no arithmetic and does not touch the register file.

Top module: `fpop_decoder`

## Requirements
- R1: A word is in the arithmetic group when (word & 0xC1F80000) == 0x81A00000 and in the compare group when the masked value is 0x81A80000. Any other word is unrecognised.
- R2: The operation field is bits 13:5, the first source index is bits 18:14, the second source index is bits 4:0 and the destination index is bits 29:25. These fields appear on their outputs for every word.
- R3: Size codes are 0 = none, 1 = single, 2 = double, 3 = quad. In the arithmetic group the opcodes below report the sizes listed.
  - Add, sub, mul and div have three operands of equal size. The single-precision codes are 0x041/0x045/0x049/0x04D, the double-precision codes are 0x042/0x046/0x04A/0x04E, and the quad codes are 0x043/0x047/0x04B/0x04F.
  - 0x069 takes two single sources and writes a double. 0x06E takes two double sources and writes a quad.
- R4: These arithmetic-group opcodes have no first source (size 0). Each entry reads as source size, then destination size.
  - Square root: 0x029 is single to single, 0x02A is double to double, 0x02B is quad to quad.
  - 0x001, 0x005 and 0x009 are single to single.
  - 0x0C4 and 0x0D1 are single to single. 0x0C6 and 0x0D2 are double to single. 0x0C7 and 0x0D3 are quad to single.
  - 0x0C8 and 0x0C9 are single to double. 0x0CB is quad to double.
  - 0x0CC and 0x0CD are single to quad. 0x0CE is double to quad.
  - Integer operands count as single.
- R5: An operand of size double with index bit 0 set is an error. An operand of size quad with index bits 1:0 not both zero is an error.
- R6: Compare-group opcodes 0x051/0x055 (single), 0x052/0x056 (double) and 0x053/0x057 (quad) have both sources of that size. Each reports destination size 0 and raises the condition-code destination flag. A nonzero destination index is an error.
- R7: An error drives the error flag high, the trap-type output to 6 and the executable flag low. With no error, a recognised word drives trap type 0 and the executable flag high.
- R8: An unrecognised word gives recognised = 0, all size codes 0, condition-code flag 0, error 0, trap type 0 and executable 0. This covers an opcode absent from its group's table and a word in neither group.
- R9: An operand whose size is 0 is never checked, so any index value in its field causes no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| insn_i | input | 32 | Instruction word |
| hit_o | output | 1 | Word recognised |
| opf_o | output | 9 | Operation field |
| rs1_sz_o | output | 2 | First source size code |
| rs2_sz_o | output | 2 | Second source size code |
| rd_sz_o | output | 2 | Destination size code |
| rd_fcc_o | output | 1 | Destination is the condition codes |
| rs1_idx_o | output | 5 | First source register index |
| rs2_idx_o | output | 5 | Second source register index |
| rd_idx_o | output | 5 | Destination register index |
| badreg_o | output | 1 | Invalid-register error |
| trap_o | output | 3 | Trap type (6 on error, else 0) |
| exec_ok_o | output | 1 | Recognised and free of error |

## Verification
Every output is a combinational function of the instruction word, so each result is due zero cycles after the word changes. The bench changes the word on a falling clock edge and compares all outputs one time unit after the following rising edge, by which point the combinational outputs have settled. One compare covers all fields at once. Every table opcode is swept with nine register-index patterns that mix aligned, odd and two-modulo-four indices. Directed words then cover the group masks and opcodes absent from each table.

// File: rtl/fpdec_pkg.sv
package fpdec_pkg;
  typedef enum logic [1:0] {
    SZ_NONE = 2'd0,
    SZ_SGL  = 2'd1,
    SZ_DBL  = 2'd2,
    SZ_QUAD = 2'd3
  } opsz_e;

  typedef enum logic [1:0] {
    GRP_NONE  = 2'd0,
    GRP_ARITH = 2'd1,
    GRP_CMP   = 2'd2
  } grp_e;

  typedef struct packed {
    logic  hit;
    opsz_e rs1;
    opsz_e rs2;
    opsz_e rd;
    logic  rd_fcc;
  } opclass_t;

  function automatic opclass_t mk_cls(opsz_e a, opsz_e b, opsz_e d, logic fcc);
    opclass_t c;
    c.hit    = 1'b1;
    c.rs1    = a;
    c.rs2    = b;
    c.rd     = d;
    c.rd_fcc = fcc;
    return c;
  endfunction
endpackage

// File: rtl/fpdec_group.sv
module fpdec_group
  import fpdec_pkg::*;
#(
  parameter int                 INSN_W      = 32,
  parameter logic [INSN_W-1:0]  GRP_MASK    = 32'hC1F8_0000,
  parameter logic [INSN_W-1:0]  ARITH_MATCH = 32'h81A0_0000,
  parameter logic [INSN_W-1:0]  CMP_MATCH   = 32'h81A8_0000
) (
  input  logic [INSN_W-1:0] insn_i,
  output grp_e              grp_o
);
  logic [INSN_W-1:0] masked;

  always_comb begin
    masked = insn_i & GRP_MASK;
    if (masked == ARITH_MATCH)    grp_o = GRP_ARITH;
    else if (masked == CMP_MATCH) grp_o = GRP_CMP;
    else                          grp_o = GRP_NONE;
  end

  always_comb begin
    if (!$isunknown(insn_i)) begin
      assert_grp_bits_R1: assert ((grp_o == GRP_NONE) || (insn_i[31:30] == 2'b10))
        else $error("group decoded with bad top bits");
    end
  end
endmodule

// File: rtl/fpdec_optable.sv
module fpdec_optable
  import fpdec_pkg::*;
#(
  parameter int OPF_W = 9
) (
  input  grp_e             grp_i,
  input  logic [OPF_W-1:0] opf_i,
  output opclass_t         cls_o
);
  always_comb begin
    cls_o = '{hit: 1'b0, rs1: SZ_NONE, rs2: SZ_NONE, rd: SZ_NONE, rd_fcc: 1'b0};
    case (grp_i)
      GRP_ARITH: begin
        case (opf_i)
          9'h001, 9'h005, 9'h009: cls_o = mk_cls(SZ_NONE, SZ_SGL,  SZ_SGL,  1'b0);
          9'h029:                 cls_o = mk_cls(SZ_NONE, SZ_SGL,  SZ_SGL,  1'b0);
          9'h02A:                 cls_o = mk_cls(SZ_NONE, SZ_DBL,  SZ_DBL,  1'b0);
          9'h02B:                 cls_o = mk_cls(SZ_NONE, SZ_QUAD, SZ_QUAD, 1'b0);
          9'h041, 9'h045, 9'h049, 9'h04D:
                                  cls_o = mk_cls(SZ_SGL,  SZ_SGL,  SZ_SGL,  1'b0);
          9'h042, 9'h046, 9'h04A, 9'h04E:
                                  cls_o = mk_cls(SZ_DBL,  SZ_DBL,  SZ_DBL,  1'b0);
          9'h043, 9'h047, 9'h04B, 9'h04F:
                                  cls_o = mk_cls(SZ_QUAD, SZ_QUAD, SZ_QUAD, 1'b0);
          9'h069:                 cls_o = mk_cls(SZ_SGL,  SZ_SGL,  SZ_DBL,  1'b0);
          9'h06E:                 cls_o = mk_cls(SZ_DBL,  SZ_DBL,  SZ_QUAD, 1'b0);
          9'h0C4, 9'h0D1:         cls_o = mk_cls(SZ_NONE, SZ_SGL,  SZ_SGL,  1'b0);
          9'h0C6, 9'h0D2:         cls_o = mk_cls(SZ_NONE, SZ_DBL,  SZ_SGL,  1'b0);
          9'h0C7, 9'h0D3:         cls_o = mk_cls(SZ_NONE, SZ_QUAD, SZ_SGL,  1'b0);
          9'h0C8, 9'h0C9:         cls_o = mk_cls(SZ_NONE, SZ_SGL,  SZ_DBL,  1'b0);
          9'h0CB:                 cls_o = mk_cls(SZ_NONE, SZ_QUAD, SZ_DBL,  1'b0);
          9'h0CC, 9'h0CD:         cls_o = mk_cls(SZ_NONE, SZ_SGL,  SZ_QUAD, 1'b0);
          9'h0CE:                 cls_o = mk_cls(SZ_NONE, SZ_DBL,  SZ_QUAD, 1'b0);
          default: ;
        endcase
      end
      GRP_CMP: begin
        case (opf_i)
          9'h051, 9'h055: cls_o = mk_cls(SZ_SGL,  SZ_SGL,  SZ_NONE, 1'b1);
          9'h052, 9'h056: cls_o = mk_cls(SZ_DBL,  SZ_DBL,  SZ_NONE, 1'b1);
          9'h053, 9'h057: cls_o = mk_cls(SZ_QUAD, SZ_QUAD, SZ_NONE, 1'b1);
          default: ;
        endcase
      end
      default: ;
    endcase
  end

  always_comb begin
    if (!$isunknown({grp_i, opf_i})) begin
      assert_fcc_only_cmp_R6: assert (!cls_o.rd_fcc || (grp_i == GRP_CMP))
        else $error("condition-code destination outside compare group");
      assert_miss_empty_R8: assert (cls_o.hit || (cls_o.rs1 == SZ_NONE && cls_o.rs2 == SZ_NONE
                                                  && cls_o.rd == SZ_NONE && !cls_o.rd_fcc))
        else $error("unrecognised opcode reports operand sizes");
    end
  end
endmodule

// File: rtl/fpdec_regchk.sv
module fpdec_regchk
  import fpdec_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  opsz_e            sz_i,
  input  logic             fcc_dest_i,
  input  logic [REG_W-1:0] idx_i,
  output logic             err_o
);
  always_comb begin
    err_o = 1'b0;
    if (fcc_dest_i) begin
      err_o = (idx_i != '0);
    end else begin
      case (sz_i)
        SZ_DBL:  err_o = idx_i[0];
        SZ_QUAD: err_o = |idx_i[1:0];
        default: err_o = 1'b0;
      endcase
    end
  end

  always_comb begin
    if (!$isunknown({sz_i, fcc_dest_i, idx_i})) begin
      assert_quad_align_R5: assert (err_o || fcc_dest_i || (sz_i != SZ_QUAD) || (idx_i[1:0] == 2'b00))
        else $error("misaligned quad operand accepted");
      assert_unused_quiet_R9: assert (!err_o || fcc_dest_i || (sz_i != SZ_NONE))
        else $error("operand of no size flagged");
    end
  end
endmodule

// File: rtl/fpop_decoder.sv
module fpop_decoder
  import fpdec_pkg::*;
#(
  parameter int INSN_W      = 32,
  parameter int OPF_W       = 9,
  parameter int REG_W       = 5,
  parameter int TRAP_W      = 3,
  parameter int TRAP_BADREG = 6,
  parameter int OPF_LSB     = 5,
  parameter int RS1_LSB     = 14,
  parameter int RS2_LSB     = 0,
  parameter int RD_LSB      = 25
) (
  input  logic [INSN_W-1:0] insn_i,
  output logic              hit_o,
  output logic [OPF_W-1:0]  opf_o,
  output logic [1:0]        rs1_sz_o,
  output logic [1:0]        rs2_sz_o,
  output logic [1:0]        rd_sz_o,
  output logic              rd_fcc_o,
  output logic [REG_W-1:0]  rs1_idx_o,
  output logic [REG_W-1:0]  rs2_idx_o,
  output logic [REG_W-1:0]  rd_idx_o,
  output logic              badreg_o,
  output logic [TRAP_W-1:0] trap_o,
  output logic              exec_ok_o
);
  localparam int NUM_OPS = 3;
  localparam logic [TRAP_W-1:0] TRAP_CODE = TRAP_W'(TRAP_BADREG);

  grp_e     grp;
  opclass_t cls;

  opsz_e            sz_a   [NUM_OPS];
  logic             fcc_a  [NUM_OPS];
  logic [REG_W-1:0] idx_a  [NUM_OPS];
  logic [NUM_OPS-1:0] err_v;

  assign opf_o     = insn_i[OPF_LSB +: OPF_W];
  assign rs1_idx_o = insn_i[RS1_LSB +: REG_W];
  assign rs2_idx_o = insn_i[RS2_LSB +: REG_W];
  assign rd_idx_o  = insn_i[RD_LSB  +: REG_W];

  fpdec_group #(.INSN_W(INSN_W)) u_grp (
    .insn_i (insn_i),
    .grp_o  (grp)
  );

  fpdec_optable #(.OPF_W(OPF_W)) u_tab (
    .grp_i (grp),
    .opf_i (opf_o),
    .cls_o (cls)
  );

  // operand slots: 0 = first source, 1 = second source, 2 = destination
  always_comb begin
    sz_a[0]  = cls.rs1;  idx_a[0] = rs1_idx_o;  fcc_a[0] = 1'b0;
    sz_a[1]  = cls.rs2;  idx_a[1] = rs2_idx_o;  fcc_a[1] = 1'b0;
    sz_a[2]  = cls.rd;   idx_a[2] = rd_idx_o;   fcc_a[2] = cls.rd_fcc;
  end

  for (genvar k = 0; k < NUM_OPS; k++) begin : g_chk
    fpdec_regchk #(.REG_W(REG_W)) u_chk (
      .sz_i       (sz_a[k]),
      .fcc_dest_i (fcc_a[k]),
      .idx_i      (idx_a[k]),
      .err_o      (err_v[k])
    );
  end

  always_comb begin
    hit_o     = cls.hit;
    rs1_sz_o  = cls.rs1;
    rs2_sz_o  = cls.rs2;
    rd_sz_o   = cls.rd;
    rd_fcc_o  = cls.rd_fcc;
    badreg_o  = cls.hit & (|err_v);
    trap_o    = badreg_o ? TRAP_CODE : '0;
    exec_ok_o = cls.hit & ~badreg_o;
  end

  always_comb begin
    if (!$isunknown(insn_i)) begin
      assert_trap_code_R7: assert (!badreg_o || (trap_o == 3'd6 && !exec_ok_o))
        else $error("error without trap type 6 or with execute");
      assert_unrecog_R8: assert (hit_o || (!badreg_o && trap_o == '0 && !exec_ok_o))
        else $error("unrecognised word reports error or execute");
      assert_fcc_rd_none_R6: assert (!rd_fcc_o || (rd_sz_o == 2'd0 && grp == GRP_CMP))
        else $error("condition-code destination with a register size");
      assert_rs1_unused_R9: assert (!(hit_o && rs1_sz_o == 2'd0) || !err_v[0])
        else $error("unused first source raised an error");
    end
  end
endmodule

// File: tb/sim_fpop_decoder.sv
module sim_fpop_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic [31:0] insn;
  logic        hit, rd_fcc, badreg, exec_ok;
  logic [8:0]  opf;
  logic [1:0]  rs1_sz, rs2_sz, rd_sz;
  logic [4:0]  rs1_idx, rs2_idx, rd_idx;
  logic [2:0]  trap;

  fpop_decoder u0 (
    .insn_i(insn), .hit_o(hit), .opf_o(opf),
    .rs1_sz_o(rs1_sz), .rs2_sz_o(rs2_sz), .rd_sz_o(rd_sz), .rd_fcc_o(rd_fcc),
    .rs1_idx_o(rs1_idx), .rs2_idx_o(rs2_idx), .rd_idx_o(rd_idx),
    .badreg_o(badreg), .trap_o(trap), .exec_ok_o(exec_ok)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // entry: [16:8] opf, [7:6] rs1 size, [5:4] rs2 size, [3:2] rd size, [1] fcc, [0] compare group
  localparam int NV = 38;
  localparam bit [16:0] VEC [NV] = '{
    {9'h041,2'd1,2'd1,2'd1,1'b0,1'b0}, {9'h042,2'd2,2'd2,2'd2,1'b0,1'b0}, {9'h043,2'd3,2'd3,2'd3,1'b0,1'b0},
    {9'h045,2'd1,2'd1,2'd1,1'b0,1'b0}, {9'h046,2'd2,2'd2,2'd2,1'b0,1'b0}, {9'h047,2'd3,2'd3,2'd3,1'b0,1'b0},
    {9'h049,2'd1,2'd1,2'd1,1'b0,1'b0}, {9'h04A,2'd2,2'd2,2'd2,1'b0,1'b0}, {9'h04B,2'd3,2'd3,2'd3,1'b0,1'b0},
    {9'h04D,2'd1,2'd1,2'd1,1'b0,1'b0}, {9'h04E,2'd2,2'd2,2'd2,1'b0,1'b0}, {9'h04F,2'd3,2'd3,2'd3,1'b0,1'b0},
    {9'h069,2'd1,2'd1,2'd2,1'b0,1'b0}, {9'h06E,2'd2,2'd2,2'd3,1'b0,1'b0},
    {9'h029,2'd0,2'd1,2'd1,1'b0,1'b0}, {9'h02A,2'd0,2'd2,2'd2,1'b0,1'b0}, {9'h02B,2'd0,2'd3,2'd3,1'b0,1'b0},
    {9'h001,2'd0,2'd1,2'd1,1'b0,1'b0}, {9'h005,2'd0,2'd1,2'd1,1'b0,1'b0}, {9'h009,2'd0,2'd1,2'd1,1'b0,1'b0},
    {9'h0C4,2'd0,2'd1,2'd1,1'b0,1'b0}, {9'h0D1,2'd0,2'd1,2'd1,1'b0,1'b0},
    {9'h0C6,2'd0,2'd2,2'd1,1'b0,1'b0}, {9'h0D2,2'd0,2'd2,2'd1,1'b0,1'b0},
    {9'h0C7,2'd0,2'd3,2'd1,1'b0,1'b0}, {9'h0D3,2'd0,2'd3,2'd1,1'b0,1'b0},
    {9'h0C8,2'd0,2'd1,2'd2,1'b0,1'b0}, {9'h0C9,2'd0,2'd1,2'd2,1'b0,1'b0},
    {9'h0CB,2'd0,2'd3,2'd2,1'b0,1'b0},
    {9'h0CC,2'd0,2'd1,2'd3,1'b0,1'b0}, {9'h0CD,2'd0,2'd1,2'd3,1'b0,1'b0}, {9'h0CE,2'd0,2'd2,2'd3,1'b0,1'b0},
    {9'h051,2'd1,2'd1,2'd0,1'b1,1'b1}, {9'h055,2'd1,2'd1,2'd0,1'b1,1'b1},
    {9'h052,2'd2,2'd2,2'd0,1'b1,1'b1}, {9'h056,2'd2,2'd2,2'd0,1'b1,1'b1},
    {9'h053,2'd3,2'd3,2'd0,1'b1,1'b1}, {9'h057,2'd3,2'd3,2'd0,1'b1,1'b1}
  };

  // index sets: rd, rs1, rs2
  localparam int NI = 9;
  localparam bit [14:0] IDX [NI] = '{
    {5'd8,5'd4,5'd12}, {5'd1,5'd4,5'd12}, {5'd4,5'd1,5'd12},
    {5'd4,5'd12,5'd1}, {5'd2,5'd4,5'd12}, {5'd4,5'd2,5'd12},
    {5'd4,5'd12,5'd2}, {5'd0,5'd0,5'd0},  {5'd3,5'd3,5'd3}
  };

  function automatic bit [31:0] mk(bit g2, bit [4:0] rd, bit [4:0] a, bit [8:0] op, bit [4:0] b);
    return {2'b10, rd, 5'b11010, g2, a, op, b};
  endfunction

  function automatic bit misal(bit [1:0] sz, bit [4:0] idx);
    if (sz == 2'd2) return idx[0];
    if (sz == 2'd3) return idx[1:0] != 2'b00;
    return 1'b0;
  endfunction

  // packed: hit, opf, rs1sz, rs2sz, rdsz, fcc, rs1, rs2, rd, badreg, trap, exec
  function automatic bit [36:0] expect_hit(bit [16:0] e, bit [31:0] w);
    bit err;
    bit [4:0] rd = w[29:25], a = w[18:14], b = w[4:0];
    err = misal(e[7:6], a) | misal(e[5:4], b) | (e[1] ? (rd != 0) : misal(e[3:2], rd));
    return {1'b1, e[16:8], e[7:6], e[5:4], e[3:2], e[1], a, b, rd,
            err, err ? 3'd6 : 3'd0, ~err};
  endfunction

  function automatic bit [36:0] expect_miss(bit [31:0] w);
    return {1'b0, w[13:5], 6'd0, 1'b0, w[18:14], w[4:0], w[29:25], 1'b0, 3'd0, 1'b0};
  endfunction

  task automatic apply_check(bit [31:0] w, bit [36:0] exp, string tag);
    logic [36:0] got;
    @(negedge clk);
    insn = w;
    @(posedge clk);
    #1;
    got = {hit, opf, rs1_sz, rs2_sz, rd_sz, rd_fcc, rs1_idx, rs2_idx, rd_idx, badreg, trap, exec_ok};
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s insn=%h actual=%h expected=%h", tag, w, got, exp);
    end
  endtask

  initial begin
    bit [31:0] w;
    bit [36:0] e;
    insn = 32'h0;
    repeat (3) @(posedge clk);
    #1;
    // reset state: idle word
    apply_check(32'h0, expect_miss(32'h0), "R8 reset idle");
    @(negedge clk);
    rst_n = 1'b1;

    // table sweep
    for (int i = 0; i < NV; i++) begin
      for (int j = 0; j < NI; j++) begin
        w = mk(VEC[i][0], IDX[j][14:10], IDX[j][9:5], VEC[i][16:8], IDX[j][4:0]);
        e = expect_hit(VEC[i], w);
        apply_check(w, e, $sformatf("%s%s%s%s op=%h",
          VEC[i][0] ? "R6 " : (VEC[i][7:6] == 2'd0 ? "R4 " : "R3 "),
          e[4] ? "R5 R7 " : "R7 ",
          VEC[i][7:6] == 2'd0 ? "R9 " : "",
          "R2", VEC[i][16:8]));
      end
    end

    // field positions with distinct indices (single add)
    w = mk(1'b0, 5'd5, 5'd7, 9'h041, 5'd9);
    apply_check(w, {1'b1, 9'h041, 2'd1, 2'd1, 2'd1, 1'b0, 5'd7, 5'd9, 5'd5, 1'b0, 3'd0, 1'b1}, "R2 fields");
    // group masks
    apply_check(32'hFFFF_FFFF, expect_miss(32'hFFFF_FFFF), "R1 all ones");
    w = mk(1'b0, 5'd0, 5'd0, 9'h041, 5'd0) ^ 32'hC000_0000;
    apply_check(w, expect_miss(w), "R1 top bits 01");
    w = mk(1'b0, 5'd0, 5'd0, 9'h041, 5'd0) | 32'h0010_0000;
    apply_check(w, expect_miss(w), "R1 bit20 set");
    w = {2'b10, 5'd0, 6'b110110, 5'd0, 9'h051, 5'd0};
    apply_check(w, expect_miss(w), "R1 neither group");
    // opcodes absent from their group's table
    w = mk(1'b0, 5'd1, 5'd1, 9'h051, 5'd1); apply_check(w, expect_miss(w), "R8 cmp code in arith group");
    w = mk(1'b1, 5'd1, 5'd1, 9'h041, 5'd1); apply_check(w, expect_miss(w), "R8 add code in cmp group");
    w = mk(1'b0, 5'd3, 5'd3, 9'h0CA, 5'd3); apply_check(w, expect_miss(w), "R8 0x0CA");
    w = mk(1'b0, 5'd3, 5'd3, 9'h0C5, 5'd3); apply_check(w, expect_miss(w), "R8 0x0C5");
    w = mk(1'b0, 5'd3, 5'd3, 9'h0D0, 5'd3); apply_check(w, expect_miss(w), "R8 0x0D0");
    w = mk(1'b1, 5'd0, 5'd0, 9'h054, 5'd0); apply_check(w, expect_miss(w), "R8 0x054 cmp");
    // unused rs1 field ignored on quad square root
    w = mk(1'b0, 5'd8, 5'd3, 9'h02B, 5'd4);
    apply_check(w, {1'b1, 9'h02B, 2'd0, 2'd3, 2'd3, 1'b0, 5'd3, 5'd4, 5'd8, 1'b0, 3'd0, 1'b1}, "R9 sqrt quad rs1=3");
    // compare rd=16 (aligned for quad but not zero) must still fail
    w = mk(1'b1, 5'd16, 5'd4, 9'h053, 5'd8);
    apply_check(w, {1'b1, 9'h053, 2'd3, 2'd3, 2'd0, 1'b1, 5'd4, 5'd8, 5'd16, 1'b1, 3'd6, 1'b0}, "R6 R7 cmp rd=16");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule